// File: doc/BRIEF.md
# Decode-Resolved Branch Fetch Controller

This block owns the fetch program counter of a five-stage in-order pipeline and decides, every cycle, which address instruction fetch uses next. Conditional branches and jumps are resolved in the decode stage. A branch is taken based on one test: whether a single register is zero or is not zero. The branch target is the sequential address of the branch plus a scaled, sign-extended offset. The jump target keeps the upper region bits of the sequential address and inserts a word index.

A static two-bit policy input selects how the already-fetched successor of a control instruction is treated. Stall mode freezes fetch and turns the successor into a bubble. Predict-not-taken discards the successor only when the branch goes. Predict-taken discards it for every control instruction, because the target only becomes known in decode. Delay-slot mode always lets the successor run. The block drives a squash for the IF/ID register and a fetch stall, and it remembers which decode slot holds a bubble so that stale decode flags in that slot are ignored.

Top module: `brfetch_unit`

## Requirements
- R1: During reset the fetch PC equals RESET_PC and squash and stall are low. In the first cycle after reset the decode slot is empty, so decode flags are ignored and next PC is RESET_PC+4.
- R2: With no control instruction in decode, next PC is the fetch PC plus 4 and both squash and stall stay low.
- R3: The three decode flag inputs select the kind of control instruction. A branch with id_br_nez_i=0 is taken when the tested register is zero. A branch with id_br_nez_i=1 is taken when the register is nonzero. A jump (id_jump_i=1) is always taken.
- R4: The taken branch target is the branch's own address plus 4, plus the 16-bit immediate sign-extended and shifted left by 2.
- R5: The jump target is the upper 4 bits of the branch's address plus 4, followed by the 26-bit index field, followed by two zero bits.
- R6: Policy 0 (stall): for any control instruction in decode, stall and squash are high. Next PC is the target when the branch is taken, and otherwise the unchanged fetch PC.
- R7: Policy 1 (predict not taken): squash is high only when the control instruction is taken, and stall stays low. Next PC is the target when taken, and otherwise the fetch PC plus 4.
- R8: Policy 2 (predict taken): squash is high for every control instruction and stall stays low. Next PC is the target when taken, and otherwise the unchanged fetch PC.
- R9: Policy 3 (one delay slot): squash and stall never rise. Next PC is the target when taken, and otherwise the fetch PC plus 4.
- R10: In the cycle after a squash, the decode slot holds a bubble. Its branch and jump flags are ignored: no squash, and next PC is the fetch PC plus 4.
- R11: Each control instruction loses one fetch cycle under policies 0 and 2. Under policy 1 it loses one cycle only when taken. Under policy 3 it loses none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Static hazard policy: 0 stall, 1 predict not taken, 2 predict taken, 3 delay slot |
| id_branch_i | input | 1 | Decode holds a conditional branch |
| id_jump_i | input | 1 | Decode holds a jump |
| id_br_nez_i | input | 1 | Branch sense: 0 taken on zero, 1 taken on nonzero |
| id_reg_i | input | XLEN | Register value tested by the branch |
| id_imm_i | input | IMM_W | Branch offset in words, signed |
| id_jidx_i | input | JIDX_W | Jump word index field |
| fetch_pc_o | output | XLEN | Address fetched this cycle |
| next_pc_o | output | XLEN | Address to fetch next cycle |
| ifid_squash_o | output | 1 | Turn the IF/ID contents into a no-op at the next edge |
| fetch_stall_o | output | 1 | Fetch is frozen this cycle |

## Verification
Two things happen on the same clock edge: the redirect of the fetch PC and the squash of the successor that was fetched too early. The sweep provokes this by placing every control kind, tested value and offset in decode under each policy. It samples next PC, squash and stall together at the falling edge, and then checks the fetch PC one edge later against a target computed arithmetically. The flags are then left asserted for one more cycle, which checks that the bubble created by the squash cannot set off a second redirect.

// File: rtl/brfetch_pkg.sv
package brfetch_pkg;

   typedef enum logic [1:0] {
      POL_STALL     = 2'd0,
      POL_NOT_TAKEN = 2'd1,
      POL_TAKEN     = 2'd2,
      POL_DELAY     = 2'd3
   } bf_policy_e;

   typedef struct packed {
      logic squash;
      logic stall;
      logic hold;
      logic redirect;
   } bf_ctl_t;

endpackage

// File: rtl/brfetch_cond.sv
module brfetch_cond #(
   parameter int XLEN = 32
) (
   input  logic            live,
   input  logic            is_branch,
   input  logic            is_jump,
   input  logic            br_nez,
   input  logic [XLEN-1:0] reg_val,
   output logic            ctl_present,
   output logic            taken
);
   logic is_zero;

   assign is_zero     = (reg_val == '0);
   assign ctl_present = live & (is_branch | is_jump);
   assign taken       = live & (is_jump | (is_branch & (br_nez ? ~is_zero : is_zero)));
endmodule

// File: rtl/brfetch_target.sv
module brfetch_target #(
   parameter int XLEN   = 32,
   parameter int IMM_W  = 16,
   parameter int JIDX_W = 26
) (
   input  logic [XLEN-1:0]   seq_pc,
   input  logic [IMM_W-1:0]  imm,
   input  logic [JIDX_W-1:0] jidx,
   input  logic              use_jump,
   output logic [XLEN-1:0]   target
);
   localparam int EXT_W     = XLEN - IMM_W;
   localparam int JREGION_W = XLEN - JIDX_W - 2;

   logic [XLEN-1:0] br_off;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] jmp_tgt;

   assign br_off = {{EXT_W{imm[IMM_W-1]}}, imm} << 2;
   assign br_tgt = seq_pc + br_off;

   generate
      if (JREGION_W > 0) begin : g_region
         assign jmp_tgt = {seq_pc[XLEN-1 -: JREGION_W], jidx, 2'b00};
      end else begin : g_flat
         assign jmp_tgt = {jidx, 2'b00};
      end
   endgenerate

   assign target = use_jump ? jmp_tgt : br_tgt;
endmodule

// File: rtl/brfetch_policy.sv
module brfetch_policy
   import brfetch_pkg::*;
(
   input  logic [1:0] policy,
   input  logic       ctl_present,
   input  logic       taken,
   output bf_ctl_t    ctl
);
   bf_policy_e pol;

   assign pol = bf_policy_e'(policy);

   always_comb begin
      ctl          = '0;
      ctl.redirect = taken;
      unique case (pol)
         POL_STALL: begin
            ctl.squash = ctl_present;
            ctl.stall  = ctl_present;
            ctl.hold   = ctl_present & ~taken;
         end
         POL_NOT_TAKEN: begin
            ctl.squash = taken;
         end
         POL_TAKEN: begin
            ctl.squash = ctl_present;
            ctl.hold   = ctl_present & ~taken;
         end
         default: begin
            ctl.squash = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/brfetch_unit.sv
module brfetch_unit
   import brfetch_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter int              IMM_W    = 16,
   parameter int              JIDX_W   = 26,
   parameter logic [XLEN-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        policy_i,
   input  logic              id_branch_i,
   input  logic              id_jump_i,
   input  logic              id_br_nez_i,
   input  logic [XLEN-1:0]   id_reg_i,
   input  logic [IMM_W-1:0]  id_imm_i,
   input  logic [JIDX_W-1:0] id_jidx_i,
   output logic [XLEN-1:0]   fetch_pc_o,
   output logic [XLEN-1:0]   next_pc_o,
   output logic              ifid_squash_o,
   output logic              fetch_stall_o
);
   localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

   initial begin
      if (IMM_W + 2 > XLEN) $fatal(1, "offset wider than the address");
      if (JIDX_W + 2 > XLEN) $fatal(1, "jump index wider than the address");
   end

   logic [XLEN-1:0] fetch_pc_q;
   logic [XLEN-1:0] id_seq_q;
   logic            id_live_q;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] target;
   logic            ctl_present;
   logic            taken;
   bf_ctl_t         ctl;
   logic [XLEN-1:0] next_pc;

   assign seq_pc = fetch_pc_q + INSN_BYTES;

   brfetch_cond #(.XLEN(XLEN)) u_cond (
      .live        (id_live_q),
      .is_branch   (id_branch_i),
      .is_jump     (id_jump_i),
      .br_nez      (id_br_nez_i),
      .reg_val     (id_reg_i),
      .ctl_present (ctl_present),
      .taken       (taken)
   );

   brfetch_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_target (
      .seq_pc   (id_seq_q),
      .imm      (id_imm_i),
      .jidx     (id_jidx_i),
      .use_jump (id_jump_i),
      .target   (target)
   );

   brfetch_policy u_policy (
      .policy      (policy_i),
      .ctl_present (ctl_present),
      .taken       (taken),
      .ctl         (ctl)
   );

   always_comb begin
      if (ctl.redirect)  next_pc = target;
      else if (ctl.hold) next_pc = fetch_pc_q;
      else               next_pc = seq_pc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_pc_q <= RESET_PC;
         id_seq_q   <= '0;
         id_live_q  <= 1'b0;
      end else begin
         fetch_pc_q <= next_pc;
         id_seq_q   <= seq_pc;
         id_live_q  <= ~ctl.squash;
      end
   end

   assign fetch_pc_o    = fetch_pc_q;
   assign next_pc_o     = next_pc;
   assign ifid_squash_o = ctl.squash;
   assign fetch_stall_o = ctl.stall;
endmodule

// File: rtl/brfetch_checks.sv
module brfetch_checks #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      policy,
   input logic [XLEN-1:0] fetch_pc,
   input logic [XLEN-1:0] next_pc,
   input logic            squash,
   input logic            stall
);
   a_r6_stall_only_in_stall_policy: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (policy == 2'd0));

   a_r6_stall_brings_squash: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> squash);

   a_r9_delay_never_squashes: assert property (@(posedge clk) disable iff (!rst_n)
      (policy == 2'd3) |-> (!squash && !stall));

   a_r7_nt_unsquashed_is_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      ((policy == 2'd1) && !squash) |-> (next_pc == fetch_pc + XLEN'(4)));

   a_r8_taken_policy_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (policy == 2'd2) |-> !stall);

   a_r10_no_back_to_back_squash: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> !squash);
endmodule

bind brfetch_unit brfetch_checks #(.XLEN(XLEN)) u_checks (
   .clk      (clk),
   .rst_n    (rst_n),
   .policy   (policy_i),
   .fetch_pc (fetch_pc_o),
   .next_pc  (next_pc_o),
   .squash   (ifid_squash_o),
   .stall    (fetch_stall_o)
);

// File: tb/brfetch_unit_bench.sv
`timescale 1ns/1ps
module brfetch_unit_bench;
   localparam int          XLEN   = 32;
   localparam int          IMM_W  = 16;
   localparam int          JIDX_W = 26;
   localparam logic [31:0] RST_PC = 32'h3000_0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  policy = 2'd0;
   logic        id_branch = 1'b0, id_jump = 1'b0, id_nez = 1'b0;
   logic [31:0] id_reg = '0;
   logic [15:0] id_imm = '0;
   logic [25:0] id_jidx = '0;
   logic [31:0] fetch_pc, next_pc;
   logic        squash, stall;

   int checks = 0;
   int errors = 0;
   int lost_seen [4];
   int lost_exp  [4];

   always #2 clk = ~clk;

   brfetch_unit #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W), .RESET_PC(RST_PC)) u_brfetch_unit (
      .clk(clk), .rst_n(rst_n), .policy_i(policy),
      .id_branch_i(id_branch), .id_jump_i(id_jump), .id_br_nez_i(id_nez),
      .id_reg_i(id_reg), .id_imm_i(id_imm), .id_jidx_i(id_jidx),
      .fetch_pc_o(fetch_pc), .next_pc_o(next_pc),
      .ifid_squash_o(squash), .fetch_stall_o(stall)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic run_case(input int pol, input int kind, input logic [31:0] rs,
                           input logic [15:0] imm, input logic [25:0] jt);
      logic [31:0] br_seq, tgt, exp_next;
      logic        present, tk, exp_sq, exp_st;
      string       rtag, ttag;
      br_seq  = RST_PC + 32'd4;
      present = (kind != 3);
      tk      = (kind == 2) || (kind == 0 && rs == 0) || (kind == 1 && rs != 0);
      tgt     = (kind == 2) ? {br_seq[31:28], jt, 2'b00}
                            : br_seq + ({{16{imm[15]}}, imm} << 2);
      ttag    = (kind == 2) ? "R5" : "R4";
      case (pol)
         0: begin rtag = "R6"; exp_sq = present; exp_st = present;
                  exp_next = tk ? tgt : (present ? RST_PC + 32'd4 : RST_PC + 32'd8); end
         1: begin rtag = "R7"; exp_sq = tk; exp_st = 1'b0;
                  exp_next = tk ? tgt : RST_PC + 32'd8; end
         2: begin rtag = "R8"; exp_sq = present; exp_st = 1'b0;
                  exp_next = tk ? tgt : (present ? RST_PC + 32'd4 : RST_PC + 32'd8); end
         default: begin rtag = "R9"; exp_sq = 1'b0; exp_st = 1'b0;
                  exp_next = tk ? tgt : RST_PC + 32'd8; end
      endcase
      if (!present) rtag = "R2";

      @(negedge clk);
      rst_n = 1'b0; policy = 2'(pol);
      id_branch = 1'b0; id_jump = 1'b0; id_nez = 1'b0;
      @(negedge clk);
      chk("R1 reset fetch pc", fetch_pc, RST_PC);
      chk("R1 reset squash", {31'd0, squash}, 32'd0);
      chk("R1 reset stall", {31'd0, stall}, 32'd0);
      id_branch = (kind == 0 || kind == 1);
      id_jump   = (kind == 2);
      id_nez    = (kind == 1);
      id_reg = rs; id_imm = imm; id_jidx = jt;
      rst_n = 1'b1;
      #1;
      chk("R1 empty slot ignored next pc", next_pc, RST_PC + 32'd4);
      chk("R1 empty slot ignored squash", {31'd0, squash}, 32'd0);
      @(negedge clk);
      chk("R2 fetch advances", fetch_pc, RST_PC + 32'd4);
      chk($sformatf("%s R3 %s next pc pol=%0d kind=%0d", rtag, ttag, pol, kind), next_pc, exp_next);
      chk($sformatf("%s R3 squash pol=%0d kind=%0d", rtag, pol, kind), {31'd0, squash}, {31'd0, exp_sq});
      chk($sformatf("%s stall pol=%0d kind=%0d", rtag, pol, kind), {31'd0, stall}, {31'd0, exp_st});
      lost_seen[pol] += int'(squash);
      lost_exp[pol]  += int'(exp_sq);
      @(negedge clk);
      chk($sformatf("%s fetch pc after edge", rtag), fetch_pc, exp_next);
      if (exp_sq) begin
         chk("R10 bubble flags ignored squash", {31'd0, squash}, 32'd0);
         chk("R10 bubble flags ignored next pc", next_pc, exp_next + 32'd4);
      end
      id_branch = 1'b0; id_jump = 1'b0; id_nez = 1'b0;
   endtask

   initial begin
      logic [31:0] rs_set [3];
      logic [15:0] imm_set [5];
      logic [25:0] jt_set [5];
      rs_set  = '{32'd0, 32'd1, 32'h8000_0000};
      imm_set = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff};
      jt_set  = '{26'h0000000, 26'h3ffffff, 26'h1234567, 26'h0000001, 26'h2aaaaaa};
      for (int p = 0; p < 4; p++) begin
         lost_seen[p] = 0;
         lost_exp[p]  = 0;
      end
      for (int p = 0; p < 4; p++)
         for (int k = 0; k < 4; k++)
            for (int r = 0; r < 3; r++)
               for (int i = 0; i < 5; i++)
                  run_case(p, k, rs_set[r], imm_set[i], jt_set[i]);
      for (int p = 0; p < 4; p++)
         chk($sformatf("R11 lost cycles policy %0d", p), 32'(lost_seen[p]), 32'(lost_exp[p]));
      chk("R11 delay policy loses nothing", 32'(lost_seen[3]), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule